// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches a synchronously sampled SRAM-style control interface: active-low chip select, write strobe and output enable, plus a 17-bit address. There is no command register. A command is hidden in a fixed chain of six consecutive read cycles. The first five addresses act as a key. The address of the sixth read chooses one of four actions: turn automatic store off, turn automatic store on, start a nonvolatile store, or start a nonvolatile recall. The chosen action leaves the block as a single-cycle pulse on its own output.

Besides the command pulses, the block keeps an automatic-store enable flag and drives a gate for the data-bus output enable. The gate is raised during ordinary reads. It is held low during the sixth read of a store or recall chain. A `busy` input marks a store or recall in progress; in the bench it comes from the testbench. While it is high, every access is ignored and the chain detector stays cleared.

Top module: `rdseq_cmd_unit`

## Requirements
- R1: After reset, all four command pulses are 0, `bus_drive` is 0 and `autostore_en` is 1.
- R2: A read cycle is `cs_n`=0, `we_n`=1 and `oe_n`=0. `bus_drive` is 1 three clock edges after a read cycle is first sampled. It is 0 when `cs_n` is high, when `oe_n` is high or when `we_n` is low.
- R3: The key is the reads 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, in that order. A sixth read then selects the command: 0x8B45 gives `cmd_as_off`, 0x4B46 gives `cmd_as_on`, 0x8FC0 gives `cmd_store`, and 0x4C63 gives `cmd_recall`. The pulse is exactly one cycle long and is high on the fourth edge after the sixth address is sampled. At most one pulse is high at a time.
- R4: `autostore_en` goes to 0 after `cmd_as_off` and to 1 after `cmd_as_on`. No other event changes it.
- R5: Address bit 16 takes no part in matching. A chain with bit 16 set on any of its reads still completes.
- R6: Any write cycle (`cs_n`=0, `we_n`=0, whatever `oe_n` is) returns the detector to the start of the chain.
- R7: A read at an address other than the next key entry aborts the chain. If that address is 0x4E38, the chain restarts with it as the first entry.
- R8: A new read is counted when `cs_n` falls, or when the low 16 address bits change while `cs_n` stays low. An address held for several cycles counts once.
- R9: During the sixth read of a store or recall chain, `bus_drive` stays 0. During the sixth read of an automatic-store on or off chain, it is 1.
- R10: While `busy` is 1, no read is counted, no command fires, `bus_drive` is 0, and the detector is cleared.
- R11: After a complete key, a sixth read at any address that is not a command code fires no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Address |
| busy | input | 1 | Store or recall in progress |
| bus_drive | output | 1 | Data-bus output-enable gate |
| autostore_en | output | 1 | Automatic-store enable flag |
| cmd_as_off | output | 1 | One-cycle pulse: turn automatic store off |
| cmd_as_on | output | 1 | One-cycle pulse: turn automatic store on |
| cmd_store | output | 1 | One-cycle pulse: start nonvolatile store |
| cmd_recall | output | 1 | One-cycle pulse: start nonvolatile recall |

## Verification
Inputs change at falling clock edges, so the first rising edge after a change samples them. `bus_drive` is due after the third rising edge. The bench reads it at the third falling edge after the read begins. A command pulse is due after the fourth rising edge. One directed case confirms that the pulse is absent at the third falling edge and present at the fourth. A negedge monitor tallies every pulse, and the tallies are compared with a bench model of the chain after each sequence. The automatic-store flag is compared with that model at the same points.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  localparam int KEY_W     = 16;
  localparam int CHAIN_LEN = 6;
  localparam int N_CMD     = 4;
  localparam int CMD_W     = $clog2(N_CMD);

  typedef enum logic [CMD_W-1:0] {
    CMD_AS_OFF = 2'd0,
    CMD_AS_ON  = 2'd1,
    CMD_STORE  = 2'd2,
    CMD_RECALL = 2'd3
  } cmd_kind_e;

  // Key entries that must precede the command address, in order.
  function automatic logic [KEY_W-1:0] chain_key(input int idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      4:       return 16'h703F;
      default: return 16'h0000;
    endcase
  endfunction

  // Command address for each command kind.
  function automatic logic [KEY_W-1:0] cmd_key(input int idx);
    case (idx)
      0:       return 16'h8B45;
      1:       return 16'h4B46;
      2:       return 16'h8FC0;
      default: return 16'h4C63;
    endcase
  endfunction

  // Store and recall release the data bus on their final read.
  function automatic logic cmd_hides_bus(input logic [CMD_W-1:0] kind);
    return (kind == CMD_STORE) || (kind == CMD_RECALL);
  endfunction

endpackage

// File: rtl/rdseq_access_decode.sv
module rdseq_access_decode #(
  parameter int ADDR_W = 17,
  parameter int KEY_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic             busy,
  output logic             rd_stb,
  output logic             rd_lvl,
  output logic             wr_stb,
  output logic [KEY_W-1:0] key
);

  logic              s_cs_n, s_we_n, s_oe_n;
  logic [ADDR_W-1:0] s_addr;
  logic              p_cs_n;
  logic [KEY_W-1:0]  p_key;
  logic              sel, fresh, rd_now, wr_now;

  // Input capture stage plus one cycle of history.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_cs_n <= 1'b1;
      s_we_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_addr <= '0;
      p_cs_n <= 1'b1;
      p_key  <= '0;
    end else begin
      s_cs_n <= cs_n;
      s_we_n <= we_n;
      s_oe_n <= oe_n;
      s_addr <= addr;
      p_cs_n <= s_cs_n;
      p_key  <= s_addr[KEY_W-1:0];
    end
  end

  // Only the low KEY_W address bits decide whether an access is new.
  always_comb begin
    sel    = !s_cs_n;
    fresh  = sel && (p_cs_n || (s_addr[KEY_W-1:0] != p_key));
    rd_now = sel && s_we_n && !s_oe_n;
    wr_now = sel && !s_we_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb <= 1'b0;
      rd_lvl <= 1'b0;
      wr_stb <= 1'b0;
      key    <= '0;
    end else begin
      rd_stb <= !busy && fresh && rd_now;
      rd_lvl <= !busy && rd_now;
      wr_stb <= !busy && wr_now;
      key    <= s_addr[KEY_W-1:0];
    end
  end

  assert_stb_is_read_R8: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> rd_lvl);

  assert_busy_mutes_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!rd_stb && !wr_stb && !rd_lvl));

endmodule

// File: rtl/rdseq_step_tracker.sv
module rdseq_step_tracker
  import rdseq_pkg::*;
#(
  parameter int KW    = KEY_W,
  parameter int CLEN  = CHAIN_LEN,
  parameter int NCMD  = N_CMD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             rd_stb,
  input  logic             rd_lvl,
  input  logic             wr_stb,
  input  logic [KW-1:0]    key,
  output logic             cmd_fire,
  output logic [CMD_W-1:0] cmd_kind,
  output logic             dq_drive
);

  localparam int STEP_W = $clog2(CLEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CLEN - 1);

  logic [STEP_W-1:0] step, step_nxt;
  logic              hide, hide_nxt;
  logic              fire_nxt;
  logic [CMD_W-1:0]  kind_nxt, kind_hit;
  logic [NCMD-1:0]   hit;
  logic              key_ok, key_first;

  // One comparator per command code.
  generate
    for (genvar k = 0; k < NCMD; k++) begin : g_cmd_cmp
      assign hit[k] = (key == cmd_key(k));
    end
  endgenerate

  always_comb begin
    kind_hit = '0;
    for (int k = 0; k < NCMD; k++)
      if (hit[k]) kind_hit = CMD_W'(k);
  end

  assign key_ok    = (step < LAST_STEP) && (key == chain_key(int'(step)));
  assign key_first = (key == chain_key(0));

  always_comb begin
    step_nxt = step;
    hide_nxt = hide;
    fire_nxt = 1'b0;
    kind_nxt = cmd_kind;
    if (wr_stb) begin
      step_nxt = '0;
      hide_nxt = 1'b0;
    end else if (rd_stb) begin
      hide_nxt = 1'b0;
      if ((step == LAST_STEP) && (|hit)) begin
        fire_nxt = 1'b1;
        kind_nxt = kind_hit;
        step_nxt = '0;
        hide_nxt = cmd_hides_bus(kind_hit);
      end else if (key_ok) begin
        step_nxt = step + 1'b1;
      end else if (key_first) begin
        step_nxt = STEP_W'(1);
      end else begin
        step_nxt = '0;
      end
    end else if (!rd_lvl) begin
      hide_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || busy) begin
      step     <= '0;
      hide     <= 1'b0;
      cmd_fire <= 1'b0;
      cmd_kind <= '0;
      dq_drive <= 1'b0;
    end else begin
      step     <= step_nxt;
      hide     <= hide_nxt;
      cmd_fire <= fire_nxt;
      cmd_kind <= kind_nxt;
      dq_drive <= rd_lvl && !hide_nxt;
    end
  end

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !busy) |=> (step == '0));

  assert_busy_clears_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (step == '0 && !cmd_fire && !dq_drive));

  assert_drive_needs_read_R2: assert property (@(posedge clk) disable iff (rst)
    dq_drive |-> $past(rd_lvl));

  assert_fire_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |-> $past(step == LAST_STEP && rd_stb));

endmodule

// File: rtl/rdseq_cmd_issue.sv
module rdseq_cmd_issue
  import rdseq_pkg::*;
#(
  parameter int NCMD = N_CMD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_fire,
  input  logic [CMD_W-1:0] cmd_kind,
  output logic [NCMD-1:0]  pulse,
  output logic             as_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= '0;
      as_en <= 1'b1;
    end else begin
      pulse <= cmd_fire ? (NCMD'(1) << cmd_kind) : '0;
      if (cmd_fire && cmd_kind == CMD_AS_OFF) as_en <= 1'b0;
      if (cmd_fire && cmd_kind == CMD_AS_ON)  as_en <= 1'b1;
    end
  end

  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |=> (pulse == '0));

  assert_flag_moves_on_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(as_en) |-> $past(cmd_fire));

endmodule

// File: rtl/rdseq_cmd_unit.sv
module rdseq_cmd_unit
  import rdseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              bus_drive,
  output logic              autostore_en,
  output logic              cmd_as_off,
  output logic              cmd_as_on,
  output logic              cmd_store,
  output logic              cmd_recall
);

  logic             rd_stb, rd_lvl, wr_stb;
  logic [KEY_W-1:0] key;
  logic             cmd_fire;
  logic [CMD_W-1:0] cmd_kind;
  logic [N_CMD-1:0] pulse;

  rdseq_access_decode #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_decode (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .busy(busy),
    .rd_stb(rd_stb), .rd_lvl(rd_lvl), .wr_stb(wr_stb), .key(key)
  );

  rdseq_step_tracker #(.KW(KEY_W), .CLEN(CHAIN_LEN), .NCMD(N_CMD)) u_track (
    .clk(clk), .rst(rst), .busy(busy),
    .rd_stb(rd_stb), .rd_lvl(rd_lvl), .wr_stb(wr_stb), .key(key),
    .cmd_fire(cmd_fire), .cmd_kind(cmd_kind), .dq_drive(bus_drive)
  );

  rdseq_cmd_issue #(.NCMD(N_CMD)) u_issue (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .cmd_kind(cmd_kind),
    .pulse(pulse), .as_en(autostore_en)
  );

  assign cmd_as_off = pulse[CMD_AS_OFF];
  assign cmd_as_on  = pulse[CMD_AS_ON];
  assign cmd_store  = pulse[CMD_STORE];
  assign cmd_recall = pulse[CMD_RECALL];

endmodule

// File: tb/rdseq_cmd_unit_test.sv
module rdseq_cmd_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [16:0] addr = '0;
  logic        bus_drive, autostore_en, cmd_as_off, cmd_as_on, cmd_store, cmd_recall;

  always #10 clk = ~clk;

  rdseq_cmd_unit uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .busy(busy), .bus_drive(bus_drive), .autostore_en(autostore_en),
    .cmd_as_off(cmd_as_off), .cmd_as_on(cmd_as_on),
    .cmd_store(cmd_store), .cmd_recall(cmd_recall)
  );

  logic [15:0] chain [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  logic [15:0] codes [4] = '{16'h8B45, 16'h4B46, 16'h8FC0, 16'h4C63};

  int total = 0, bad = 0;
  int exp_step = 0;
  bit exp_as = 1'b1;
  int seen [4] = '{0, 0, 0, 0};
  int want [4] = '{0, 0, 0, 0};

  always @(negedge clk) if (!rst) begin
    seen[0] += int'(cmd_as_off);
    seen[1] += int'(cmd_as_on);
    seen[2] += int'(cmd_store);
    seen[3] += int'(cmd_recall);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Reference model of the chain, driven by each counted read.
  task automatic model_read(input logic [15:0] k, output bit hide, output bit last);
    int idx;
    idx = -1;
    hide = 1'b0;
    last = 1'b0;
    if (exp_step == 5)
      for (int i = 0; i < 4; i++) if (k == codes[i]) idx = i;
    if (idx >= 0) begin
      want[idx]++;
      hide = (idx >= 2);
      last = 1'b1;
      if (idx == 0) exp_as = 1'b0;
      if (idx == 1) exp_as = 1'b1;
      exp_step = 0;
    end else if (exp_step < 5 && k == chain[exp_step]) exp_step++;
    else if (k == chain[0]) exp_step = 1;
    else exp_step = 0;
  endtask

  task automatic do_read(input logic [16:0] a, input int hold, input bit desel);
    bit hide, last;
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
    if (busy) begin hide = 1'b1; last = 1'b0; end
    else model_read(a[15:0], hide, last);
    repeat (3) @(negedge clk);
    chk(bus_drive == !hide, (last || busy) ? (busy ? "R10" : "R9") : "R2",
        "bus_drive on read", int'(bus_drive), int'(!hide));
    repeat (hold - 3) @(negedge clk);
    if (desel) begin
      cs_n = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [16:0] a, input logic oe);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = a;
    if (!busy) exp_step = 0;
    repeat (3) @(negedge clk);
    chk(bus_drive == 1'b0, "R6", "bus_drive during write", int'(bus_drive), 0);
    cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_noread(input logic [16:0] a);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = a;
    repeat (3) @(negedge clk);
    chk(bus_drive == 1'b0, "R2", "bus_drive with oe high", int'(bus_drive), 0);
    cs_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic key5(input bit top);
    for (int i = 0; i < 5; i++) do_read({top, chain[i]}, 4, 1'b1);
  endtask

  task automatic check_counts(input string req);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++)
      chk(seen[i] == want[i], req, $sformatf("pulse count kind %0d", i), seen[i], want[i]);
    chk(autostore_en == exp_as, "R4", "autostore_en", int'(autostore_en), int'(exp_as));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    bit hide, last;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(bus_drive == 1'b0, "R1", "bus_drive", int'(bus_drive), 0);
    chk({cmd_as_off, cmd_as_on, cmd_store, cmd_recall} == 4'b0, "R1", "pulses",
        int'({cmd_as_off, cmd_as_on, cmd_store, cmd_recall}), 0);
    chk(autostore_en == 1'b1, "R1", "autostore_en", int'(autostore_en), 1);

    // R3, R9: store chain
    key5(1'b0); do_read({1'b0, codes[2]}, 4, 1'b1); check_counts("R3");

    // R3: exact latency of a recall pulse
    key5(1'b0);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = {1'b0, codes[3]};
    model_read(codes[3], hide, last);
    repeat (3) @(negedge clk);
    chk(cmd_recall == 1'b0, "R3", "recall too early", int'(cmd_recall), 0);
    chk(bus_drive == 1'b0, "R9", "bus released on recall", int'(bus_drive), 0);
    @(negedge clk);
    chk(cmd_recall == 1'b1, "R3", "recall at fourth edge", int'(cmd_recall), 1);
    @(negedge clk);
    chk(cmd_recall == 1'b0, "R3", "recall one cycle", int'(cmd_recall), 0);
    cs_n = 1'b1;
    check_counts("R3");

    // R4, R5: off with top bit set, then on
    key5(1'b1); do_read({1'b1, codes[0]}, 4, 1'b1); check_counts("R5");
    key5(1'b0); do_read({1'b1, codes[1]}, 4, 1'b1); check_counts("R4");

    // R6: writes break the chain, with oe low and high
    for (int i = 0; i < 3; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    do_write(17'h00001, 1'b0);
    for (int i = 3; i < 5; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    do_read({1'b0, codes[2]}, 4, 1'b1); check_counts("R6");
    key5(1'b0); do_write(17'h00002, 1'b1); do_read({1'b0, codes[0]}, 4, 1'b1);
    check_counts("R6");

    // R7: abort, and restart with the first key entry
    for (int i = 0; i < 3; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    do_read(17'h01234, 4, 1'b1);
    for (int i = 3; i < 5; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    do_read({1'b0, codes[2]}, 4, 1'b1); check_counts("R7");
    for (int i = 0; i < 3; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    key5(1'b0); do_read({1'b0, codes[1]}, 4, 1'b1); check_counts("R7");

    // R8: long hold counts once; chain by address change without deselect
    do_read({1'b0, chain[0]}, 9, 1'b1);
    for (int i = 1; i < 5; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    do_read({1'b0, codes[0]}, 4, 1'b1); check_counts("R8");
    for (int i = 0; i < 5; i++) do_read({1'b0, chain[i]}, 4, 1'b0);
    do_read({1'b0, codes[1]}, 4, 1'b1); check_counts("R8");

    // R11: wrong sixth address
    key5(1'b0); do_read(17'h01111, 4, 1'b1); check_counts("R11");

    // R2: oe high is not a read
    do_noread(17'h04E38);

    // R10: busy mutes everything, and clears a partial chain
    @(negedge clk); busy = 1'b1; exp_step = 0;
    key5(1'b0); do_read({1'b0, codes[2]}, 4, 1'b1); check_counts("R10");
    @(negedge clk); busy = 1'b0;
    for (int i = 0; i < 3; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    @(negedge clk); busy = 1'b1; exp_step = 0;
    @(negedge clk); busy = 1'b0;
    for (int i = 3; i < 5; i++) do_read({1'b0, chain[i]}, 4, 1'b1);
    do_read({1'b0, codes[3]}, 4, 1'b1); check_counts("R10");

    // Random mix checked against the model (R3, R7, R11)
    for (int n = 0; n < 400; n++) begin
      int r;
      logic top;
      r = int'($urandom % 100);
      top = 1'($urandom % 2);
      if (r < 55)
        do_read({top, (exp_step < 5) ? chain[exp_step] : codes[$urandom % 4]}, 4, 1'b1);
      else if (r < 70) do_read({top, 16'($urandom)}, 4, 1'b1);
      else if (r < 80) do_read({top, chain[0]}, 4, 1'b1);
      else if (r < 90) do_write({top, 16'($urandom)}, 1'($urandom % 2));
      else do_noread({top, 16'($urandom)});
    end
    check_counts("R3");

    summary();
  end

endmodule